// File: doc/BRIEF.md
# TDM Input Bit Delay Aligner

This block takes one serial TDM input line and lines its bits up against a master frame pulse. It runs on a sampling clock at four times the bit rate, so a bit cell spans four clock cycles. Each cycle is one quarter-bit step. At a frame pulse the block reads a 5-bit delay field and a mode bit. From these it works out where the first bit cell of the delayed frame starts and at which quarter inside each cell the line is sampled.

In fractional-delay mode the whole field is a delay in quarter-bit steps, from 0 to 7 3/4 bits. The bit is then taken at the middle of its cell. In sampling-point-select mode the upper three bits give a whole-bit delay of 0 to 7 bits. The lower two bits pick the quarter of the cell where the sample is taken. This lets a system move the sampling instant away from a jittery or late-settling edge.

Each recovered bit comes out with a one-cycle valid strobe. The first bit of each delayed frame also carries a frame-start marker. The delay is measured in bit periods of the stream's own rate, because the sampling clock is tied to that rate.

Top module: `tdm_bit_aligner`

## Requirements
- R1: After reset, and until the first frame pulse is seen, `bit_valid` and `frame_start` stay low and `bit_data` is 0.
- R2: With `sel_mode` = 0, the first bit is sampled at the clock edge `delay_cfg` + 2 cycles after the edge that sees `frame_pulse`. The delay is in quarter-bit steps and the sample sits at mid-cell.
- R3: With `sel_mode` = 1, `delay_cfg[4:2]` delays the first bit cell by that many whole bits, 4 clock cycles each.
- R4: With `sel_mode` = 1, `delay_cfg[1:0]` picks the sample point within the cell. The codes are 00 = 3/4 (3 cycles in), 01 = 4/4 (4 cycles), 10 = 1/4 (1 cycle) and 11 = 2/4 (2 cycles). With zero delay and code 01, the first sample falls at the end of the first bit cell.
- R5: After the first sample, further samples follow every 4 clock cycles until the next frame pulse.
- R6: `frame_start` is high in the same cycle as `bit_valid` for the first bit of a frame, and is low for every other bit.
- R7: `bit_valid` is a one-cycle pulse, visible in the cycle after the sampling edge. `bit_data` then holds the value `rx_data` had at that edge.
- R8: Changes to `sel_mode` or `delay_cfg` between frame pulses do not alter the timing of the current frame.
- R9: A frame pulse restarts the alignment at once. No sample from the old frame is taken at or after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Master frame pulse, high for one clock cycle |
| rx_data | input | 1 | Serial TDM input line |
| sel_mode | input | 1 | 0 = fractional delay, 1 = integer delay plus sample-point select |
| delay_cfg | input | 5 | Delay / sample-point field, read at the frame pulse |
| bit_data | output | 1 | Recovered bit |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |
| frame_start | output | 1 | Marks the first recovered bit of a delayed frame |

## Verification
The bench walks the extremes of the field in both modes. It covers zero delay, the largest quarter delay of 31 steps, the largest whole delay of 7 bits, and all four sample-point codes. A decoder that swapped the code order, or that added the sample offset without the mid-cell term, would shift the first strobe by one to three cycles, and the bench would catch it. After each pulse the bench scrambles the mode and the field, so a design that reads them outside the pulse would drift in timing. The bench also lines up a new pulse with the edge where the old frame would sample. A design that let the old cadence run through the restart would give a strobe in the first cycle of the new frame.

// File: rtl/tdm_bit_aligner.sv
module tdm_bit_aligner #(
  parameter int INT_BITS = 3,
  parameter int PT_BITS  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_pulse,
  input  logic                        rx_data,
  input  logic                        sel_mode,
  input  logic [INT_BITS+PT_BITS-1:0] delay_cfg,
  output logic                        bit_data,
  output logic                        bit_valid,
  output logic                        frame_start
);
  localparam int CELL    = 1 << PT_BITS;
  localparam int FIELD_W = INT_BITS + PT_BITS;
  localparam int MAX_WT  = (1 << FIELD_W) - 1 + CELL / 2;
  localparam int CNT_W   = $clog2(MAX_WT + 1);

  logic             active;
  logic             first;
  logic [CNT_W-1:0] wait_cnt;
  logic [CNT_W-1:0] pt_off;
  logic [CNT_W-1:0] first_wait;

  always_comb begin
    pt_off = CNT_W'(delay_cfg[PT_BITS-1:0]) + CNT_W'(CELL - 1);
    if (pt_off > CNT_W'(CELL)) pt_off = pt_off - CNT_W'(CELL);
  end

  assign first_wait = sel_mode
    ? CNT_W'({delay_cfg[FIELD_W-1:PT_BITS], {PT_BITS{1'b0}}}) + pt_off
    : CNT_W'(delay_cfg) + CNT_W'(CELL / 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      first       <= 1'b0;
      wait_cnt    <= '0;
      bit_data    <= 1'b0;
      bit_valid   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      bit_valid   <= 1'b0;
      frame_start <= 1'b0;
      if (frame_pulse) begin
        active   <= 1'b1;
        first    <= 1'b1;
        wait_cnt <= first_wait;
      end else if (active) begin
        if (wait_cnt == CNT_W'(1)) begin
          bit_data    <= rx_data;
          bit_valid   <= 1'b1;
          frame_start <= first;
          first       <= 1'b0;
          wait_cnt    <= CNT_W'(CELL);
        end else begin
          wait_cnt <= wait_cnt - CNT_W'(1);
        end
      end
    end
  end

  AST_IDLE_UNTIL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !bit_valid && !frame_start); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (wait_cnt >= CNT_W'(1)) && (wait_cnt <= CNT_W'(MAX_WT))); // R5
  AST_START_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bit_valid); // R6
  AST_BIT_IS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> bit_data == $past(rx_data)); // R7
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid); // R7
endmodule

// File: tb/tdm_bit_aligner_bench.sv
module tdm_bit_aligner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic       rx_data = 1'b0;
  logic       sel_mode = 1'b0;
  logic [4:0] delay_cfg = '0;
  logic       bit_data, bit_valid, frame_start;

  int tests = 0;
  int failed = 0;
  int e = 0;
  bit done = 1'b0;

  tdm_bit_aligner u_tdm_bit_aligner (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rx_data(rx_data),
    .sel_mode(sel_mode), .delay_cfg(delay_cfg),
    .bit_data(bit_data), .bit_valid(bit_valid), .frame_start(frame_start)
  );

  always #10 clk = ~clk;
  always @(posedge clk) e <= e + 1;

  function automatic logic pat(input int p);
    return logic'((p ^ (p >> 1) ^ (p >> 3)) & 1);
  endfunction

  always @(negedge clk) rx_data = pat(e);

  // {mode, field, expected cycles from pulse edge to first sampling edge}
  localparam logic [11:0] VEC [11] = '{
    {1'b0, 5'd0,       6'd2},
    {1'b0, 5'd1,       6'd3},
    {1'b0, 5'd5,       6'd7},
    {1'b0, 5'd31,      6'd33},
    {1'b1, 5'b000_01,  6'd4},
    {1'b1, 5'b000_10,  6'd1},
    {1'b1, 5'b000_11,  6'd2},
    {1'b1, 5'b000_00,  6'd3},
    {1'b1, 5'b011_00,  6'd15},
    {1'b1, 5'b111_01,  6'd32},
    {1'b1, 5'b111_10,  6'd29}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic m, input logic [4:0] d, input int k,
                           input int ncyc, input string req);
    int t0;
    int bad_v = -1, bad_d = -1, bad_s = -1, first_seen = -1;
    @(negedge clk);
    frame_pulse = 1'b1; sel_mode = m; delay_cfg = d;
    t0 = e + 1;
    @(negedge clk);
    frame_pulse = 1'b0; sel_mode = ~m; delay_cfg = ~d;  // R8: ignored until next pulse
    for (int i = 0; i < ncyc; i++) begin
      int rel;
      bit ev;
      rel = e - t0;
      ev = (rel >= k) && (((rel - k) % 4) == 0);
      if (bit_valid && first_seen < 0) first_seen = rel;
      if ((bit_valid !== ev) && bad_v < 0) bad_v = rel;
      if (bit_valid && (bit_data !== pat(e - 1)) && bad_d < 0) bad_d = rel;
      if ((frame_start !== (rel == k)) && bad_s < 0) bad_s = rel;
      @(negedge clk);
    end
    check(first_seen == k, req, "first sample offset", first_seen, k);
    check(bad_v < 0, "R5/R8", "strobe cadence, first bad offset", bad_v, -1);
    check(bad_d < 0, "R7", "sampled data, first bad offset", bad_d, -1);
    check(bad_s < 0, "R6", "frame start marker, first bad offset", bad_s, -1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check(bit_valid == 0 && frame_start == 0 && bit_data == 0, "R1", "reset outputs",
          {bit_valid, frame_start, bit_data}, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      seen += int'(bit_valid) + int'(frame_start);
    end
    check(seen == 0, "R1", "strobes before first pulse", seen, 0);

    for (int i = 0; i < 11; i++) begin
      logic [11:0] v;
      v = VEC[i];
      run_frame(v[11], v[10:6], int'(v[5:0]), 44, v[11] ? "R3/R4" : "R2");
    end

    run_frame(1'b1, 5'b000_01, 4, 120, "R5");
    run_frame(1'b0, 5'd0, 2, 8, "R9");
    run_frame(1'b1, 5'b111_01, 32, 40, "R9");

    run_frame(1'b0, 5'd3, 5, 12, "R2");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      seen += int'(bit_valid) + int'(frame_start);
    end
    check(seen == 0, "R1", "strobes after mid-frame reset", seen, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule